// File: doc/BRIEF.md
# Three-stage pipelined RV32I subset core

A compact 32-bit integer core that runs a fixed set of seventeen base RISC-V instructions: register and immediate arithmetic (add, sub, and, slt, addi, andi, slti), the upper-immediate forms lui and auipc, byte and word loads and stores (lb, lw, sb, sw), the branches beq and blt, and the jumps jal and jalr. Work is split over three pipeline stages. The first stage presents the program counter to instruction memory. The second decodes the captured word and reads the register file. The third computes, talks to data memory and writes the register file, all in one cycle.

Because the result of every instruction is written in the same stage that computes it, a dependent instruction directly behind it needs only a read-during-write bypass inside the register file. No forwarding network or stall is required. A taken branch or a jump is resolved in the last stage. It loads the program counter with the target and turns the two younger, wrongly fetched instructions into bubbles. Instruction memory and data memory are separate ports, both read combinationally within the cycle. A data store is committed by the memory on the clock edge when any byte strobe is high.

Top module: `rv3_core`

## Requirements
- R1: add, sub, and, slt (signed), addi, andi and slti produce the same register results as strict one-at-a-time execution of the program, and the data stores appear at the ports in program order with the same address, data and strobes.
- R2: While rst is high, imem_addr is 0 and dmem_wstrb is 0. With no redirect, imem_addr advances by 4 on every clock after reset, so the first two cycles after release fetch addresses 4 and 8.
- R3: An instruction that reads a register written by the instruction directly ahead of it receives the new value (register-file write-to-read bypass).
- R4: Register x0 always reads as zero. Writes aimed at x0 are dropped and are never bypassed.
- R5: A taken branch, jal or jalr sets imem_addr to the target on the next cycle and discards the two instructions behind it, which cause no store and no register write.
- R6: jal and jalr write the address of the following instruction (own PC + 4) to rd. jalr jumps to rs1 + imm with bit 0 cleared, so every fetch address stays even.
- R7: lw/sw use dmem_wstrb = 4'b1111. sb drives a one-hot strobe, bit n for address low bits n, with the source byte copied into all four lanes of dmem_wdata. lb returns the byte in lane n of dmem_rdata, sign-extended.
- R8: beq branches on equality and blt on signed less-than, to own PC + sign-extended B immediate. When not taken, execution continues at PC + 4.
- R9: lui writes the U immediate with the low 12 bits zero, and auipc writes its own PC plus the U immediate.
- R10: A load followed directly by an instruction that uses the loaded register gives the loaded value to that instruction without any stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (registered program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the load or store in the last stage |
| dmem_wdata | output | 32 | Store data, byte copied to all lanes for sb |
| dmem_wstrb | output | 4 | Byte write strobes, all zero when no store |
| dmem_rdata | input | 32 | Data word at dmem_addr, same cycle |

## Verification
The hardest thing to reach from the ports is the flushed shadow behind a redirect. A wrong-path instruction is only seen if it has a visible side effect. So the test program places stores directly behind a taken branch, and register writes behind a jal and behind a jalr with an odd offset. Any escape then shows up as an unexpected store or a corrupted register. Register state is only visible through memory, so the program ends by storing twenty registers into a dump area. Dependency chains, a load followed directly by its use, writes to x0 and not-taken branches run back to back ahead of that dump. A behavioural instruction-level model in the bench predicts every store in order and the final memory image.

// File: rtl/rv3_pkg.sv
package rv3_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_REG    = 7'b0110011;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_SLT} alu_op_e;
  typedef enum logic [1:0] {WB_ALU, WB_LOAD, WB_LINK} wb_sel_e;

  typedef struct packed {
    logic    valid;
    logic    reg_we;
    alu_op_e alu_op;
    logic    a_pc;
    logic    a_zero;
    logic    b_imm;
    logic    ld;
    logic    st;
    logic    byte_sz;
    logic    branch;
    logic    br_lt;
    logic    jump;
    wb_sel_e wb_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '0;
endpackage

// File: rtl/rv3_decode.sv
module rv3_decode
  import rv3_pkg::*;
(
  input  logic              in_valid,
  input  logic [31:0]       instr,
  output ctrl_t             ctrl,
  output logic [XLEN-1:0]   imm,
  output logic [REG_AW-1:0] rs1,
  output logic [REG_AW-1:0] rs2,
  output logic [REG_AW-1:0] rd
);
  logic [6:0] opc, f7;
  logic [2:0] f3;
  ctrl_t      c;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];
  assign rs1 = instr[19:15];
  assign rs2 = instr[24:20];
  assign rd  = instr[11:7];

  always_comb begin
    c   = CTRL_NOP;
    imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
    case (opc)
      OPC_LUI: begin
        c.valid = 1'b1; c.reg_we = 1'b1; c.a_zero = 1'b1; c.b_imm = 1'b1;
        imm = {instr[31:12], 12'b0};
      end
      OPC_AUIPC: begin
        c.valid = 1'b1; c.reg_we = 1'b1; c.a_pc = 1'b1; c.b_imm = 1'b1;
        imm = {instr[31:12], 12'b0};
      end
      OPC_JAL: begin
        c.valid = 1'b1; c.reg_we = 1'b1; c.jump = 1'b1; c.a_pc = 1'b1;
        c.b_imm = 1'b1; c.wb_sel = WB_LINK;
        imm = {{(XLEN-20){instr[31]}}, instr[19:12], instr[20], instr[30:21], 1'b0};
      end
      OPC_JALR: if (f3 == 3'b000) begin
        c.valid = 1'b1; c.reg_we = 1'b1; c.jump = 1'b1; c.b_imm = 1'b1;
        c.wb_sel = WB_LINK;
      end
      OPC_BRANCH: if (f3 == 3'b000 || f3 == 3'b100) begin
        c.valid = 1'b1; c.branch = 1'b1; c.br_lt = f3[2];
        imm = {{(XLEN-12){instr[31]}}, instr[7], instr[30:25], instr[11:8], 1'b0};
      end
      OPC_LOAD: if (f3 == 3'b000 || f3 == 3'b010) begin
        c.valid = 1'b1; c.reg_we = 1'b1; c.ld = 1'b1; c.b_imm = 1'b1;
        c.byte_sz = ~f3[1]; c.wb_sel = WB_LOAD;
      end
      OPC_STORE: if (f3 == 3'b000 || f3 == 3'b010) begin
        c.valid = 1'b1; c.st = 1'b1; c.b_imm = 1'b1; c.byte_sz = ~f3[1];
        imm = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
      end
      OPC_IMM: begin
        c.b_imm = 1'b1; c.reg_we = 1'b1;
        case (f3)
          3'b000:  begin c.valid = 1'b1; c.alu_op = ALU_ADD; end
          3'b010:  begin c.valid = 1'b1; c.alu_op = ALU_SLT; end
          3'b111:  begin c.valid = 1'b1; c.alu_op = ALU_AND; end
          default: c.valid = 1'b0;
        endcase
      end
      OPC_REG: begin
        c.reg_we = 1'b1;
        if (f7 == 7'b0000000 && f3 == 3'b000) begin c.valid = 1'b1; c.alu_op = ALU_ADD; end
        if (f7 == 7'b0100000 && f3 == 3'b000) begin c.valid = 1'b1; c.alu_op = ALU_SUB; end
        if (f7 == 7'b0000000 && f3 == 3'b010) begin c.valid = 1'b1; c.alu_op = ALU_SLT; end
        if (f7 == 7'b0000000 && f3 == 3'b111) begin c.valid = 1'b1; c.alu_op = ALU_AND; end
      end
      default: c = CTRL_NOP;
    endcase
    ctrl = (in_valid && c.valid) ? c : CTRL_NOP;
  end
endmodule

// File: rtl/rv3_regfile.sv
module rv3_regfile #(
  parameter int NREG   = 32,
  parameter int XLEN   = 32,
  parameter int NPORTS = 2,
  localparam int AW    = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [XLEN-1:0]            wdata,
  input  logic [NPORTS-1:0][AW-1:0]  raddr,
  output logic [NPORTS-1:0][XLEN-1:0] rdata
);
  logic [XLEN-1:0] cells [NREG];
  logic            wr_live;

  assign wr_live = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_live) cells[waddr] <= wdata;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == '0)                  rdata[p] = '0;
      else if (wr_live && raddr[p] == waddr) rdata[p] = wdata;
      else                                 rdata[p] = cells[raddr[p]];
    end

    p_x0_zero_r4: assert property (@(posedge clk) disable iff (rst)
      (raddr[p] == '0) |-> (rdata[p] == '0));
    p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
      (we && waddr != '0 && raddr[p] == waddr) |-> (rdata[p] == wdata));
  end
endmodule

// File: rtl/rv3_exec.sv
module rv3_exec
  import rv3_pkg::*;
#(
  localparam int BYTES  = XLEN / 8,
  localparam int LANE_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   rs1v,
  input  logic [XLEN-1:0]   rs2v,
  input  logic [XLEN-1:0]   imm,
  input  logic [XLEN-1:0]   ld_word,
  output logic              wb_we,
  output logic [XLEN-1:0]   wb_data,
  output logic              redirect,
  output logic [XLEN-1:0]   target,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic [BYTES-1:0]  mem_wstrb
);
  logic [XLEN-1:0]   op_a, op_b, sum, alu_res, ld_val;
  logic [LANE_W-1:0] lane;
  logic [7:0]        ld_byte;
  logic              br_hit;

  assign op_a = ctrl.a_zero ? '0 : (ctrl.a_pc ? pc : rs1v);
  assign op_b = ctrl.b_imm ? imm : rs2v;
  assign sum  = op_a + op_b;

  always_comb begin
    case (ctrl.alu_op)
      ALU_SUB: alu_res = op_a - op_b;
      ALU_AND: alu_res = op_a & op_b;
      ALU_SLT: alu_res = {{(XLEN-1){1'b0}}, $signed(op_a) < $signed(op_b)};
      default: alu_res = sum;
    endcase
  end

  assign lane     = sum[LANE_W-1:0];
  assign ld_byte  = ld_word[{lane, 3'b000} +: 8];
  assign ld_val   = ctrl.byte_sz ? {{(XLEN-8){ld_byte[7]}}, ld_byte} : ld_word;

  assign mem_addr  = sum;
  assign mem_wdata = ctrl.byte_sz ? {BYTES{rs2v[7:0]}} : rs2v;
  assign mem_wstrb = !(ctrl.valid && ctrl.st) ? '0 :
                     (ctrl.byte_sz ? (BYTES'(1) << lane) : '1);

  assign br_hit   = ctrl.br_lt ? ($signed(rs1v) < $signed(rs2v)) : (rs1v == rs2v);
  assign redirect = ctrl.valid && (ctrl.jump || (ctrl.branch && br_hit));
  assign target   = ctrl.branch ? (pc + imm) : {sum[XLEN-1:1], 1'b0};

  assign wb_we = ctrl.valid && ctrl.reg_we;
  always_comb begin
    case (ctrl.wb_sel)
      WB_LOAD: wb_data = ld_val;
      WB_LINK: wb_data = pc + XLEN'(BYTES);
      default: wb_data = alu_res;
    endcase
  end

  p_strobe_shape_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_wstrb != '0) |-> ($onehot0(mem_wstrb) || (mem_wstrb == '1)));
  p_no_store_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl.valid |-> (mem_wstrb == '0) && !redirect && !wb_we);
endmodule

// File: rtl/rv3_core.sv
module rv3_core
  import rv3_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int              NREG     = 32,
  localparam int             BYTES    = XLEN / 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [XLEN-1:0]  imem_addr,
  input  logic [31:0]      imem_rdata,
  output logic [XLEN-1:0]  dmem_addr,
  output logic [XLEN-1:0]  dmem_wdata,
  output logic [BYTES-1:0] dmem_wstrb,
  input  logic [XLEN-1:0]  dmem_rdata
);
  logic [XLEN-1:0]   pc_q;
  logic              fd_valid_q;
  logic [XLEN-1:0]   fd_pc_q;
  logic [31:0]       fd_instr_q;
  ctrl_t             de_ctrl_q;
  logic [XLEN-1:0]   de_pc_q, de_rs1v_q, de_rs2v_q, de_imm_q;
  logic [REG_AW-1:0] de_rd_q;

  ctrl_t                          dec_ctrl;
  logic [XLEN-1:0]                dec_imm;
  logic [REG_AW-1:0]              dec_rs1, dec_rs2, dec_rd;
  logic [1:0][REG_AW-1:0]         rf_raddr;
  logic [1:0][XLEN-1:0]           rf_rdata;
  logic                           wb_we, redirect;
  logic [XLEN-1:0]                wb_data, target;

  assign imem_addr = pc_q;

  rv3_decode u_decode (
    .in_valid (fd_valid_q), .instr (fd_instr_q), .ctrl (dec_ctrl),
    .imm (dec_imm), .rs1 (dec_rs1), .rs2 (dec_rs2), .rd (dec_rd)
  );

  assign rf_raddr = {dec_rs2, dec_rs1};

  rv3_regfile #(.NREG(NREG), .XLEN(XLEN), .NPORTS(2)) u_regs (
    .clk (clk), .rst (rst), .we (wb_we), .waddr (de_rd_q), .wdata (wb_data),
    .raddr (rf_raddr), .rdata (rf_rdata)
  );

  rv3_exec u_exec (
    .clk (clk), .rst (rst), .ctrl (de_ctrl_q), .pc (de_pc_q),
    .rs1v (de_rs1v_q), .rs2v (de_rs2v_q), .imm (de_imm_q), .ld_word (dmem_rdata),
    .wb_we (wb_we), .wb_data (wb_data), .redirect (redirect), .target (target),
    .mem_addr (dmem_addr), .mem_wdata (dmem_wdata), .mem_wstrb (dmem_wstrb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= RESET_PC;
      fd_valid_q <= 1'b0;
      de_ctrl_q  <= CTRL_NOP;
    end else if (redirect) begin
      pc_q       <= target;
      fd_valid_q <= 1'b0;
      de_ctrl_q  <= CTRL_NOP;
    end else begin
      pc_q       <= pc_q + XLEN'(BYTES);
      fd_valid_q <= 1'b1;
      de_ctrl_q  <= dec_ctrl;
    end
  end

  always_ff @(posedge clk) begin
    fd_pc_q    <= pc_q;
    fd_instr_q <= imem_rdata;
    de_pc_q    <= fd_pc_q;
    de_rs1v_q  <= rf_rdata[0];
    de_rs2v_q  <= rf_rdata[1];
    de_imm_q   <= dec_imm;
    de_rd_q    <= dec_rd;
  end

  p_flush_bubbles_r5: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (!fd_valid_q && !de_ctrl_q.valid));
  p_redirect_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (imem_addr == $past(target)));
  p_seq_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> (imem_addr == $past(imem_addr) + XLEN'(BYTES)));
  p_fetch_even_r6: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (imem_addr[0] == 1'b0));
endmodule

// File: tb/test_rv3_core.sv
`timescale 1ns/1ps
module test_rv3_core;
  localparam int WORDS = 64;
  localparam logic [31:0] HALT = 32'h0000006f;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic [3:0]  dmem_wstrb;

  rv3_core i_rv3_core (
    .clk (clk), .rst (rst), .imem_addr (imem_addr), .imem_rdata (imem_rdata),
    .dmem_addr (dmem_addr), .dmem_wdata (dmem_wdata), .dmem_wstrb (dmem_wstrb),
    .dmem_rdata (dmem_rdata)
  );

  logic [31:0] imem [WORDS];
  logic [31:0] dmem [WORDS];
  logic [31:0] rmem [WORDS];
  logic [31:0] q_addr [$];
  logic [31:0] q_data [$];
  logic [3:0]  q_strb [$];
  int nchk = 0, nfail = 0, cyc = 0;
  bit misaligned = 1'b0;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    for (int b = 0; b < 4; b++)
      if (dmem_wstrb[b]) dmem[dmem_addr[7:2]][8*b +: 8] <= dmem_wdata[8*b +: 8];
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] e_r(input logic [6:0] f7, input int rs2, input int rs1,
                                      input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(input int imm, input int rs1, input logic [2:0] f3,
                                      input int rd, input logic [6:0] op);
    return {12'(imm), 5'(rs1), f3, 5'(rd), op};
  endfunction
  function automatic logic [31:0] e_s(input int imm, input int rs2, input int rs1,
                                      input logic [2:0] f3);
    logic [11:0] v = 12'(imm);
    return {v[11:5], 5'(rs2), 5'(rs1), f3, v[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(input int imm, input int rs2, input int rs1,
                                      input logic [2:0] f3);
    logic [12:0] v = 13'(imm);
    return {v[12], v[10:5], 5'(rs2), 5'(rs1), f3, v[4:1], v[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_u(input int imm20, input int rd, input logic [6:0] op);
    return {20'(imm20), 5'(rd), op};
  endfunction
  function automatic logic [31:0] e_j(input int imm, input int rd);
    logic [20:0] v = 21'(imm);
    return {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'b1101111};
  endfunction

  // Behavioural instruction-at-a-time model
  task automatic run_model();
    logic [31:0] r [32];
    logic [31:0] pc, w, nxt, res, a, iv, sv, bv, jv, word;
    logic [7:0]  by;
    logic [3:0]  st;
    bit we;
    for (int k = 0; k < 32; k++) r[k] = '0;
    pc = '0;
    for (int step = 0; step < 2000; step++) begin
      w = imem[pc[7:2]];
      if (w == HALT) break;
      iv = {{20{w[31]}}, w[31:20]};
      sv = {{20{w[31]}}, w[31:25], w[11:7]};
      bv = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
      jv = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
      nxt = pc + 4; we = 1'b0; res = '0;
      case (w[6:0])
        7'b0110111: begin res = {w[31:12], 12'b0}; we = 1; end
        7'b0010111: begin res = pc + {w[31:12], 12'b0}; we = 1; end
        7'b1101111: begin res = pc + 4; we = 1; nxt = pc + jv; end
        7'b1100111: begin res = pc + 4; we = 1; nxt = (r[w[19:15]] + iv) & ~32'd1; end
        7'b1100011: begin
          if (w[14:12] == 3'b000 ? (r[w[19:15]] == r[w[24:20]])
                                 : ($signed(r[w[19:15]]) < $signed(r[w[24:20]])))
            nxt = pc + bv;
        end
        7'b0000011: begin
          a = r[w[19:15]] + iv; word = rmem[a[7:2]]; we = 1;
          by = word[8*a[1:0] +: 8];
          res = (w[14:12] == 3'b000) ? {{24{by[7]}}, by} : word;
        end
        7'b0100011: begin
          a = r[w[19:15]] + sv;
          if (w[14:12] == 3'b000) begin
            st = 4'b0001 << a[1:0]; word = {4{r[w[24:20]][7:0]}};
          end else begin
            st = 4'b1111; word = r[w[24:20]];
          end
          for (int b = 0; b < 4; b++) if (st[b]) rmem[a[7:2]][8*b +: 8] = word[8*b +: 8];
          q_addr.push_back(a); q_data.push_back(word); q_strb.push_back(st);
        end
        7'b0010011: begin
          we = 1;
          case (w[14:12])
            3'b000: res = r[w[19:15]] + iv;
            3'b010: res = {31'b0, $signed(r[w[19:15]]) < $signed(iv)};
            default: res = r[w[19:15]] & iv;
          endcase
        end
        default: begin
          we = 1;
          case (w[14:12])
            3'b000: res = w[30] ? r[w[19:15]] - r[w[24:20]] : r[w[19:15]] + r[w[24:20]];
            3'b010: res = {31'b0, $signed(r[w[19:15]]) < $signed(r[w[24:20]])};
            default: res = r[w[19:15]] & r[w[24:20]];
          endcase
        end
      endcase
      if (we && w[11:7] != 5'd0) r[w[11:7]] = res;
      pc = nxt;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && imem_addr[1:0] != 2'b00) misaligned = 1'b1;
    if (!rst && dmem_wstrb != 4'b0000) begin
      if (q_addr.size() == 0) begin
        check(1'b0, "R5", "store not expected", dmem_addr, 32'h0);
      end else begin
        check(dmem_addr == q_addr[0], "R1", "store address", dmem_addr, q_addr[0]);
        check(dmem_wdata == q_data[0], "R7", "store data", dmem_wdata, q_data[0]);
        check(dmem_wstrb == q_strb[0], "R7", "store strobe", {28'b0, dmem_wstrb}, {28'b0, q_strb[0]});
        void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_strb.pop_front());
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      check(1'b0, "R2", "watchdog expired", cyc, 32'd20000);
      summary();
      $finish;
    end
  end

  function automatic logic [31:0] dump(input int k);
    return dmem[32 + k];
  endfunction

  initial begin
    int n;
    string rq;
    for (int k = 0; k < WORDS; k++) begin
      imem[k] = HALT; dmem[k] = '0; rmem[k] = '0;
    end
    n = 0;
    imem[n++] = e_i(5, 0, 3'b000, 1, 7'b0010011);       // addi x1,x0,5
    imem[n++] = e_i(-3, 1, 3'b000, 2, 7'b0010011);      // addi x2,x1,-3
    imem[n++] = e_r(7'h00, 2, 1, 3'b000, 3);            // add x3,x1,x2
    imem[n++] = e_r(7'h20, 3, 2, 3'b000, 4);            // sub x4,x2,x3
    imem[n++] = e_r(7'h00, 4, 3, 3'b111, 5);            // and x5,x3,x4
    imem[n++] = e_r(7'h00, 1, 4, 3'b010, 6);            // slt x6,x4,x1
    imem[n++] = e_i(-1, 1, 3'b010, 7, 7'b0010011);      // slti x7,x1,-1
    imem[n++] = e_i(32'hF0, 4, 3'b111, 8, 7'b0010011);  // andi x8,x4,0xf0
    imem[n++] = e_u(32'h12345, 9, 7'b0110111);          // lui x9
    imem[n++] = e_u(1, 10, 7'b0010111);                 // auipc x10,1 (pc 36)
    imem[n++] = e_i(7, 0, 3'b000, 0, 7'b0010011);       // addi x0,x0,7
    imem[n++] = e_r(7'h00, 0, 0, 3'b000, 11);           // add x11,x0,x0
    imem[n++] = e_s(0, 9, 0, 3'b010);                   // sw x9,0(x0)
    imem[n++] = e_s(5, 4, 0, 3'b000);                   // sb x4,5(x0)
    imem[n++] = e_i(5, 0, 3'b000, 12, 7'b0000011);      // lb x12,5(x0)
    imem[n++] = e_i(0, 0, 3'b010, 13, 7'b0000011);      // lw x13,0(x0)
    imem[n++] = e_r(7'h00, 1, 13, 3'b000, 17);          // add x17,x13,x1
    imem[n++] = e_b(12, 1, 1, 3'b000);                  // beq taken
    imem[n++] = e_s(32'h40, 1, 0, 3'b010);              // shadow store
    imem[n++] = e_s(32'h44, 1, 0, 3'b010);              // shadow store
    imem[n++] = e_b(8, 1, 4, 3'b100);                   // blt x4,x1 taken
    imem[n++] = e_i(99, 0, 3'b000, 14, 7'b0010011);     // skipped
    imem[n++] = e_b(8, 4, 1, 3'b100);                   // blt x1,x4 not taken
    imem[n++] = e_b(8, 2, 1, 3'b000);                   // beq x1,x2 not taken
    imem[n++] = e_i(1, 6, 3'b000, 14, 7'b0010011);      // addi x14,x6,1
    imem[n++] = e_j(8, 15);                             // jal x15,+8 (pc 100)
    imem[n++] = e_i(77, 0, 3'b000, 14, 7'b0010011);     // skipped
    imem[n++] = e_u(0, 20, 7'b0010111);                 // auipc x20,0 (pc 108)
    imem[n++] = e_i(13, 20, 3'b000, 16, 7'b1100111);    // jalr x16,13(x20)
    imem[n++] = e_i(55, 0, 3'b000, 14, 7'b0010011);     // skipped
    imem[n++] = e_i(0, 4, 3'b010, 18, 7'b0010011);      // slti x18,x4,0
    imem[n++] = e_b(8, 4, 4, 3'b100);                   // blt x4,x4 not taken
    imem[n++] = e_i(-1, 0, 3'b000, 19, 7'b0010011);     // addi x19,x0,-1
    for (int k = 1; k <= 20; k++) imem[n++] = e_s(32'h80 + 4*k, k, 0, 3'b010);
    imem[n++] = HALT;
    run_model();

    repeat (3) begin
      @(negedge clk);
      check(imem_addr == 32'h0, "R2", "fetch address in reset", imem_addr, 32'h0);
      check(dmem_wstrb == 4'h0, "R2", "strobe in reset", {28'b0, dmem_wstrb}, 32'h0);
    end
    rst = 1'b0;
    @(negedge clk);
    check(imem_addr == 32'h4, "R2", "first fetch step", imem_addr, 32'h4);
    @(negedge clk);
    check(imem_addr == 32'h8, "R2", "second fetch step", imem_addr, 32'h8);
    repeat (200) @(negedge clk);

    check(q_addr.size() == 0, "R5", "stores outstanding", q_addr.size(), 32'h0);
    for (int k = 0; k < WORDS; k++) begin
      rq = (k == 16 || k == 17) ? "R5" : ((k == 1) ? "R7" : "R1");
      check(dmem[k] == rmem[k], rq, $sformatf("memory word %0d", k), dmem[k], rmem[k]);
    end
    check(dump(2) == 32'd2, "R3", "x2 after back-to-back", dump(2), 32'd2);
    check(dump(3) == 32'd7, "R3", "x3 after back-to-back", dump(3), 32'd7);
    check(dump(4) == 32'hFFFFFFFB, "R1", "x4 sub", dump(4), 32'hFFFFFFFB);
    check(dump(6) == 32'd1, "R1", "x6 slt", dump(6), 32'd1);
    check(dump(11) == 32'd0, "R4", "x0 reads zero", dump(11), 32'd0);
    check(dmem[1] == 32'h0000FB00, "R7", "sb lane 1", dmem[1], 32'h0000FB00);
    check(dump(12) == 32'hFFFFFFFB, "R7", "lb sign extend", dump(12), 32'hFFFFFFFB);
    check(dump(17) == 32'h12345005, "R10", "load then use", dump(17), 32'h12345005);
    check(dump(14) == 32'd2, "R8", "branch path", dump(14), 32'd2);
    check(dump(18) == 32'd1, "R8", "signed compare", dump(18), 32'd1);
    check(dump(15) == 32'd104, "R6", "jal link", dump(15), 32'd104);
    check(dump(16) == 32'd116, "R6", "jalr link", dump(16), 32'd116);
    check(!misaligned, "R6", "fetch alignment", {31'b0, misaligned}, 32'h0);
    check(dump(9) == 32'h12345000, "R9", "lui", dump(9), 32'h12345000);
    check(dump(10) == 32'h00001024, "R9", "auipc", dump(10), 32'h00001024);
    check(dmem[16] == 32'h0, "R5", "flushed store slot", dmem[16], 32'h0);
    summary();
    $finish;
  end
endmodule